// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire management bus of an Ethernet PHY. It generates the management clock from the system clock and serialises clause-22 read and write frames onto the bidirectional data line. It also turns the line around for the PHY's reply and shifts the reply into a 16-bit result register.

A host sets up the transfer through six word-indexed registers:

- The mode register holds the clock divider and a preamble-skip bit.
- The address register holds the PHY and register addresses.
- The write-data register holds the value for a write.

The host then raises a read or write bit in the command register and polls the busy bit in the status register until it drops. After a read, the result register holds the PHY's reply.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The management clock period, in system clock cycles, equals mode bits 7:0 with bit 0 forced to zero; a value of 0 or 1 gives a period of 2.
- R2: The data output changes only right after a falling management clock edge, so it is stable at every rising edge where the PHY samples it.
- R3: A write with mode bit 8 clear drives 64 bits, most significant first: 32 ones, start 01, opcode 01, PHY address (address register bits 4:0), register address (address register bits 12:8), turnaround 10, then write-data bits 15:0.
- R4: With mode bit 8 set, the 32 ones are skipped and a write drives only the remaining 32 bits.
- R5: A read drives the ones (unless skipped), 01, opcode 10 and both addresses. It then releases the line (output enable low) for the two turnaround bits and 16 data bits. Incoming data is sampled on rising clock edges, most significant bit first, into read-data bits 15:0.
- R6: Status bit 1 (busy) is set from the cycle after a command is accepted until the rising edge that samples the last frame bit.
- R7: A command is taken only on a 0-to-1 change of command bit 1 (read) or bit 2 (write) while busy is clear. A change seen while busy starts no frame, either then or later.
- R8: If read and write bits rise together, a read frame is run.
- R9: Command bit 0 (scan) starts no frame. Status bits 0 and 2 always read 0.
- R10: Registers are selected by word index: 0 mode, 1 command, 2 address, 3 write data, 4 read data, 5 status. All reset to 0. Writable registers read back only their defined bits (mode 8:0, command 2:0, address 12:8 and 4:0).
- R11: The output enable is low after reset and returns low at the first falling clock edge after a frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register word index |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the selected index (combinational) |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven to the pad |
| mdio_oe_o | output | 1 | Pad output enable, high while the master drives |

## Verification
The bench models a PHY that records every bit driven at a rising management clock edge and answers reads once it has counted the header bits.

- An off-by-one in the bit counter or in the preamble length changes the captured bit count: 64 or 32 for a write, 46 or 14 for a read. So does a master that keeps driving through the turnaround.
- Divider values 0, 1, 6 and 7 expose a missing floor or a failure to ignore bit 0, because the measured clock period comes out wrong.
- Re-raising a command bit while busy, raising only the scan bit, and raising read and write together catch acceptance logic that queues commands, treats scan as a frame, or picks the wrong opcode. Each of these shows up as an extra or missing frame, or as a wrong header.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [2:0] RI_MODE  = 3'd0;
  localparam logic [2:0] RI_CMD   = 3'd1;
  localparam logic [2:0] RI_ADDR  = 3'd2;
  localparam logic [2:0] RI_WDATA = 3'd3;
  localparam logic [2:0] RI_RDATA = 3'd4;
  localparam logic [2:0] RI_STAT  = 3'd5;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;

  localparam int unsigned CMD_SCAN_BIT  = 0;
  localparam int unsigned CMD_READ_BIT  = 1;
  localparam int unsigned CMD_WRITE_BIT = 2;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int unsigned HALF_W = DIV_W - 1;

  logic [DIV_W-1:0]  div_even, div_eff;
  logic [HALF_W-1:0] half_m1, cnt_q;
  logic              mdc_q, wrap;

  // bit 0 dropped; zero floors to 2
  assign div_even = {div_i[DIV_W-1:1], 1'b0};
  assign div_eff  = (div_even == '0) ? DIV_W'(2) : div_even;
  assign half_m1  = div_eff[DIV_W-1:1] - HALF_W'(1);
  assign wrap     = (cnt_q >= half_m1);

  assign rise_o = wrap & ~mdc_q;
  assign fall_o = wrap &  mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  AST_RISE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R1
  AST_MDC_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> mdc_o); // R1
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic              nopre_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int unsigned FRAME_W = 4 + 2*ADDR_W + 2 + DATA_W;
  localparam int unsigned IDX_W   = $clog2(FRAME_W + PRE_LEN);
  localparam int unsigned FIDX_W  = $clog2(FRAME_W);
  localparam int unsigned REL_LEN = DATA_W + 2;

  logic               busy_q, active_q, rd_q, nopre_q, mdio_q, oe_q;
  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q, start_idx, nxt_idx;
  logic [DATA_W-1:0]  sh_q, rdata_q, sh_next;
  logic               nxt_bit, nxt_oe, last_bit;

  assign start_idx = nopre_q ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W + PRE_LEN - 1);
  assign nxt_idx   = active_q ? (idx_q - IDX_W'(1)) : start_idx;
  assign nxt_bit   = (nxt_idx >= IDX_W'(FRAME_W)) ? 1'b1 : frame_q[nxt_idx[FIDX_W-1:0]];
  assign nxt_oe    = !(rd_q && (nxt_idx < IDX_W'(REL_LEN)));
  assign last_bit  = rise_i && active_q && (idx_q == '0);
  assign sh_next   = {sh_q[DATA_W-2:0], mdio_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      nopre_q  <= 1'b0;
      frame_q  <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      rdata_q  <= '0;
      mdio_q   <= 1'b1;
      oe_q     <= 1'b0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      rd_q    <= rd_i;
      nopre_q <= nopre_i;
      frame_q <= {SOF_BITS, rd_i ? OP_READ : OP_WRITE, phy_i, reg_i,
                  rd_i ? 2'b00 : TA_WRITE, rd_i ? '0 : wdata_i};
    end else if (busy_q) begin
      if (fall_i) begin
        active_q <= 1'b1;
        idx_q    <= nxt_idx;
        mdio_q   <= nxt_bit;
        oe_q     <= nxt_oe;
      end
      if (rise_i && active_q) begin
        if (rd_q && idx_q < IDX_W'(DATA_W)) sh_q <= sh_next;
        if (last_bit) begin
          busy_q   <= 1'b0;
          active_q <= 1'b0;
          if (rd_q) rdata_q <= sh_next;
        end
      end
    end else if (fall_i) begin
      oe_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign rdata_o   = rdata_q;
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;

  AST_BUSY_UNTIL_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_bit) |=> busy_o); // R6
  AST_START_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R7
  AST_RELEASED_FOR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && active_q && rd_q && idx_q < IDX_W'(DATA_W)) |-> !mdio_oe_o); // R5
  AST_HOLD_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> $stable(mdio_o)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_bit |=> !busy_o); // R6
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_idx_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mdc_o,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int unsigned REG_LSB = 8;
  localparam int unsigned MODE_W  = DIV_W + 1;

  logic [MODE_W-1:0] mode_q;
  logic [2:0]        cmd_q, cmd_prev_q;
  logic [ADDR_W-1:0] phy_q, regad_q;
  logic [DATA_W-1:0] wdata_q, rdata;
  logic              busy, rise, fall, rd_rise, wr_rise, start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      cmd_q      <= '0;
      cmd_prev_q <= '0;
      phy_q      <= '0;
      regad_q    <= '0;
      wdata_q    <= '0;
    end else begin
      cmd_prev_q <= cmd_q;
      if (reg_we_i) begin
        case (reg_idx_i)
          RI_MODE:  mode_q  <= reg_wdata_i[MODE_W-1:0];
          RI_CMD:   cmd_q   <= reg_wdata_i[2:0];
          RI_ADDR: begin
            phy_q   <= reg_wdata_i[ADDR_W-1:0];
            regad_q <= reg_wdata_i[REG_LSB +: ADDR_W];
          end
          RI_WDATA: wdata_q <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  // edge-triggered acceptance; read outranks write
  assign rd_rise = cmd_q[CMD_READ_BIT]  & ~cmd_prev_q[CMD_READ_BIT];
  assign wr_rise = cmd_q[CMD_WRITE_BIT] & ~cmd_prev_q[CMD_WRITE_BIT];
  assign start   = !busy && (rd_rise || wr_rise);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_idx_i)
      RI_MODE:  reg_rdata_o = DATA_W'(mode_q);
      RI_CMD:   reg_rdata_o = DATA_W'(cmd_q);
      RI_ADDR: begin
        reg_rdata_o[ADDR_W-1:0]          = phy_q;
        reg_rdata_o[REG_LSB +: ADDR_W]   = regad_q;
      end
      RI_WDATA: reg_rdata_o = wdata_q;
      RI_RDATA: reg_rdata_o = rdata;
      RI_STAT:  reg_rdata_o = DATA_W'({1'b0, busy, 1'b0});
      default:  reg_rdata_o = '0;
    endcase
  end

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (mode_q[DIV_W-1:0]),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rd_i      (rd_rise),
    .nopre_i   (mode_q[DIV_W]),
    .phy_i     (phy_q),
    .reg_i     (regad_q),
    .wdata_i   (wdata_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .rdata_o   (rdata),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy); // R6
  AST_SCAN_ALONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !rd_rise && !wr_rise) |=> !busy); // R9
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  idx = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        mdc, mdio_in, mdio_out, mdio_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mdio_mgmt_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_i(mdio_in), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe)
  );

  // PHY model and observers, all at the system clock falling edge
  logic        mon_en = 1'b0;
  logic        mdc_prev = 1'b0, mdio_prev = 1'b1;
  logic [63:0] obs = '0;
  int          obs_n = 0;
  int          hdr_target = 1000;
  logic [17:0] feed = '0;
  int          feed_n = 0;
  int          cyc = 0, last_rise = 0, last_period = 0;
  int          r2_viol = 0;

  initial mdio_in = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (mdc && !mdc_prev) begin
        last_period = cyc - last_rise;
        last_rise = cyc;
        if (mdio_oe) begin
          obs = {obs[62:0], mdio_out};
          obs_n++;
        end
      end
      if (!mdc && mdc_prev && !mdio_oe && obs_n >= hdr_target && feed_n < 18) begin
        mdio_in = feed[17];
        feed = {feed[16:0], 1'b0};
        feed_n++;
      end
      if (mdio_out !== mdio_prev && !(!mdc && mdc_prev)) r2_viol++;
    end
    mdc_prev = mdc;
    mdio_prev = mdio_out;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] i, input logic [15:0] v);
    @(negedge clk);
    we = 1'b1; idx = i; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] i, output logic [15:0] v);
    @(negedge clk);
    idx = i;
    #1 v = rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] s;
    for (int k = 0; k < 4000; k++) begin
      reg_rd(3'd5, s);
      if (!s[1]) return;
    end
    check(1'b0, tag, 64'(s), 64'h0);
  endtask

  task automatic arm(input int hdr, input logic [15:0] d);
    obs = '0; obs_n = 0; hdr_target = hdr;
    feed = {2'b10, d}; feed_n = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int r = 0; r < 6; r++) begin
      reg_rd(3'(r), v);
      check(v == 16'h0, "R10 reset value", 64'(v), 64'h0);
    end
    check(mdio_oe == 1'b0, "R11 oe after reset", 64'(mdio_oe), 64'h0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    reg_wr(3'd0, 16'hFFFF); reg_rd(3'd0, v);
    check(v == 16'h01FF, "R10 mode readback", 64'(v), 64'h01FF);
    reg_wr(3'd2, 16'hFFFF); reg_rd(3'd2, v);
    check(v == 16'h1F1F, "R10 address readback", 64'(v), 64'h1F1F);
    reg_wr(3'd3, 16'h5AA5); reg_rd(3'd3, v);
    check(v == 16'h5AA5, "R10 write data readback", 64'(v), 64'h5AA5);
    reg_wr(3'd1, 16'hFFF8); reg_rd(3'd1, v);
    check(v == 16'h0000, "R10 command undefined bits", 64'(v), 64'h0);
  endtask

  task automatic t_div(input logic [15:0] m, input int exp);
    reg_wr(3'd0, m);
    repeat (40) @(negedge clk);
    #1 check(last_period == exp, "R1 mdc period", 64'(last_period), 64'(exp));
  endtask

  task automatic t_write(input bit nopre, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    logic [15:0] s;
    logic [31:0] body;
    body = {2'b01, 2'b01, phy, ra, 2'b10, d};
    reg_wr(3'd1, 16'h0);
    reg_wr(3'd0, {7'b0, nopre, 8'h04});
    reg_wr(3'd2, {3'b0, ra, 3'b0, phy});
    reg_wr(3'd3, d);
    arm(1000, 16'h0);
    reg_wr(3'd1, 16'h0004);
    reg_rd(3'd5, s);
    check(s == 16'h0002, "R6 busy after write accept", 64'(s), 64'h2);
    wait_idle("R6 write completes");
    if (!nopre) begin
      check(obs_n == 64, "R3 write bit count", 64'(obs_n), 64'd64);
      check(obs == {32'hFFFF_FFFF, body}, "R3 write frame", obs, {32'hFFFF_FFFF, body});
    end else begin
      check(obs_n == 32, "R4 write bit count no preamble", 64'(obs_n), 64'd32);
      check(obs[31:0] == body, "R4 write frame no preamble", 64'(obs[31:0]), 64'(body));
    end
  endtask

  task automatic t_read(input bit nopre, input logic [7:0] div, input logic [4:0] phy,
                        input logic [4:0] ra, input logic [15:0] d, input logic [2:0] cmd, input string tag);
    logic [15:0] v;
    logic [13:0] hdr;
    int n;
    hdr = {2'b01, 2'b10, phy, ra};
    n = nopre ? 14 : 46;
    reg_wr(3'd1, 16'h0);
    reg_wr(3'd0, {7'b0, nopre, div});
    reg_wr(3'd2, {3'b0, ra, 3'b0, phy});
    arm(n, d);
    reg_wr(3'd1, {13'b0, cmd});
    wait_idle({tag, " completes"});
    check(obs_n == n, {tag, " driven bit count"}, 64'(obs_n), 64'(n));
    check(obs[13:0] == hdr, {tag, " header"}, 64'(obs[13:0]), 64'(hdr));
    if (!nopre)
      check(obs[45:14] == 32'hFFFF_FFFF, {tag, " preamble"}, 64'(obs[45:14]), 64'hFFFF_FFFF);
    reg_rd(3'd4, v);
    check(v == d, {tag, " read data"}, 64'(v), 64'(d));
    repeat (12) @(negedge clk);
    #1 check(mdio_oe == 1'b0, "R11 oe low after frame", 64'(mdio_oe), 64'h0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] s, v;
    reg_wr(3'd1, 16'h0);
    reg_wr(3'd0, 16'h0004);
    arm(1000, 16'h0);
    reg_wr(3'd1, 16'h0004);
    reg_wr(3'd1, 16'h0000);
    reg_wr(3'd1, 16'h0002);
    wait_idle("R7 first frame completes");
    check(obs_n == 64, "R7 one frame only", 64'(obs_n), 64'd64);
    repeat (400) @(negedge clk);
    reg_rd(3'd5, s);
    check(s == 16'h0, "R7 no late start", 64'(s), 64'h0);
    check(obs_n == 64, "R7 no extra bits", 64'(obs_n), 64'd64);
    reg_rd(3'd4, v);
    check(v == 16'h8001, "R7 read data untouched", 64'(v), 64'h8001);
  endtask

  task automatic t_scan();
    logic [15:0] s;
    reg_wr(3'd1, 16'h0);
    arm(1000, 16'h0);
    reg_wr(3'd1, 16'h0001);
    repeat (200) @(negedge clk);
    reg_rd(3'd5, s);
    check(s == 16'h0, "R9 scan starts nothing, status", 64'(s), 64'h0);
    check(obs_n == 0, "R9 scan drives nothing", 64'(obs_n), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    t_reset();
    t_regs();
    t_div(16'h0000, 2);
    t_div(16'h0001, 2);
    t_div(16'h0006, 6);
    t_div(16'h0007, 6);
    t_write(1'b0, 5'h15, 5'h0A, 16'hA5C3);
    t_write(1'b1, 5'h03, 5'h1C, 16'h1E87);
    t_read(1'b0, 8'h04, 5'h11, 5'h02, 16'h3C96, 3'b010, "R5 read");
    t_read(1'b1, 8'h02, 5'h1F, 5'h15, 16'h8001, 3'b010, "R5 read no preamble");
    t_busy_ignore();
    t_scan();
    t_read(1'b0, 8'h06, 5'h08, 5'h01, 16'h7E42, 3'b110, "R8 read wins");
    check(r2_viol == 0, "R2 mdio changes only after mdc fall", 64'(r2_viol), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule